// File: doc/BRIEF.md
# Multilevel Interrupt Controller with Non-Maskable Sources

This block gathers interrupt conditions from peripherals and decides which one a small CPU core takes next. Every source owns a pending flag. Maskable sources also carry an enable bit and a two-bit priority level. A global enable bit gates every maskable source. A fixed group of non-maskable sources has its own enable bits and ignores the global bit. The winner's vector address is computed from its index. The block then runs the core's response sequence: a return-address push phase, then a handler-entry phase. After that the vector address is offered to the core on a valid/ready beat.

The controller records which priority levels are in service, and whether a non-maskable handler is running. A maskable request is accepted only when its level is above every level in service. Nothing is accepted while a non-maskable handler runs. The in-service state is released only by the dedicated return-from-interrupt pulse, which clears the most recent entry.

Acceptance waits for the core to report an instruction boundary, so a multi-cycle instruction always completes first. A configuration-unlock pulse blocks acceptance for a fixed window. The vector beat follows valid/ready rules. Once `vec_valid` rises, it and `vec_addr` hold steady until `vec_ready` is seen high on a clock edge. No new request is accepted until that beat completes. The core may hold `vec_ready` low for as long as it needs.

Top module: `irq_hub`

## Requirements
- R1: A pending flag sets on the clock edge after its source's event pulse, whatever the enables, levels or global bit are. An event in the same cycle as a clear of that flag wins, and the flag stays set. Flag bit k belongs to vector index k+1. Bits 0..NNMI-1 are the non-maskable sources and bits NNMI.. are maskable sources 0.. in order.
- R2: The flag of the accepted source clears on the acceptance edge.
- R3: A 1 in bit k of `flag_clr` clears flag k on the next edge.
- R4: A request that cannot be served stays pending and is served once conditions allow. Held requests are served in priority order. Blocking conditions are a higher request, its own enable, the global bit, or a busy level.
- R5: A non-maskable source fires only when its bit in `nmi_en` is 1.
- R6: A pending, enabled non-maskable request is taken while `gie` is 0. The global bit changes only on a cycle with `gie_we` high, taking `gie_wdata`. It resets to 0.
- R7: While `nmi_active` is 1, no request of either class is accepted.
- R8: Non-maskable requests beat maskable ones. Among non-maskable requests, the lowest index wins. Among maskable requests, the highest level wins, and at equal level the lowest index wins.
- R9: `busy` rises on the acceptance edge. `vec_valid` rises exactly 8 edges later, after PUSH_CYC=5 push cycles and JUMP_CYC=3 entry cycles. `vec_valid` and `vec_addr` hold until `vec_ready` is sampled high. `busy` falls on that edge.
- R10: No request is accepted on an edge where `core_boundary` is 0.
- R11: If `ccp_unlock` is high at edge U, no request is accepted at edges U through U+3. Acceptance is possible again from U+4.
- R12: `lvl_active` and `nmi_active` stay unchanged except on acceptance, which sets the entry, or on a `reti` pulse. A `reti` pulse clears `nmi_active` if it is set, and otherwise clears the highest set bit of `lvl_active`.
- R13: A maskable request needs `gie`=1, its enable bit, and a nonzero level. Level encoding is 00 off, 01 low, 10 medium, 11 high, and `lvl_active` bit n-1 stands for level n. The request's level must also exceed the highest level set in `lvl_active`.
- R14: `vec_addr` equals VEC_BASE + 2*(k+1) for winning flag bit k. Index 0 is left to reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_event | input | NSRC | Maskable condition pulses |
| nmi_event | input | NNMI | Non-maskable condition pulses |
| flag_clr | input | NNMI+NSRC | Write-one-to-clear of pending flags |
| src_en | input | NSRC | Maskable source enables |
| src_lvl | input | 2*NSRC | Two-bit level per maskable source |
| nmi_en | input | NNMI | Non-maskable source enables |
| gie_we | input | 1 | Global enable write strobe |
| gie_wdata | input | 1 | Global enable write value |
| ccp_unlock | input | 1 | Configuration-unlock pulse |
| core_boundary | input | 1 | Core is at an instruction boundary |
| reti | input | 1 | Return-from-interrupt pulse |
| vec_ready | input | 1 | Core accepts the vector beat |
| gie | output | 1 | Global enable state |
| flags | output | NNMI+NSRC | Pending flags |
| lvl_active | output | 3 | In-service bits for levels 1..3 |
| nmi_active | output | 1 | Non-maskable handler in service |
| busy | output | 1 | Response sequence in progress |
| vec_valid | output | 1 | Vector beat valid |
| vec_addr | output | AW | Vector address |

## Verification
The assertions assume the core never pulses `reti` while `busy` is high. They also assume that the core, once `vec_valid` is seen, holds `vec_ready` only for the cycles in which it wants the beat. The bench's return pulses and ready pulses are only issued after a beat has completed, so it stays within these assumptions. Random rounds load random enables, levels and event bursts while `core_boundary` is low. A bench model then predicts each winner, and every service ends with a return pulse, so arbitration always starts from an empty in-service state. Directed cases cover nesting, non-maskable blocking, the unlock window and back-pressure.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_PUSH = 2'd1,
    SEQ_JUMP = 2'd2,
    SEQ_VEC  = 2'd3
  } seq_state_e;

  // one-hot in-service bit for a level code (00 gives none)
  function automatic logic [2:0] lvl_onehot(input logic [1:0] lvl);
    logic [2:0] oh;
    case (lvl)
      2'd1:    oh = 3'b001;
      2'd2:    oh = 3'b010;
      2'd3:    oh = 3'b100;
      default: oh = 3'b000;
    endcase
    return oh;
  endfunction

  // highest level number currently in service
  function automatic logic [1:0] top_level(input logic [2:0] act);
    logic [1:0] t;
    if (act[2])      t = 2'd3;
    else if (act[1]) t = 2'd2;
    else if (act[0]) t = 2'd1;
    else             t = 2'd0;
    return t;
  endfunction

endpackage

// File: rtl/irq_flags.sv
module irq_flags #(
  parameter int NT = 10,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NT-1:0] set_pulse,
  input  logic [NT-1:0] clr_w1c,
  input  logic          take,
  input  logic [IW-1:0] take_idx,
  output logic [NT-1:0] flags
);

  for (genvar k = 0; k < NT; k++) begin : g_flag
    logic hit_take;
    assign hit_take = take && (take_idx == IW'(k));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flags[k] <= 1'b0;
      end else if (set_pulse[k]) begin
        flags[k] <= 1'b1;
      end else if (clr_w1c[k] || hit_take) begin
        flags[k] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_hub_pkg::*;
#(
  parameter int NSRC = 8,
  parameter int NNMI = 2,
  parameter int IW   = 4,
  localparam int NT  = NNMI + NSRC
) (
  input  logic [NT-1:0]     flags,
  input  logic [NSRC-1:0]   src_en,
  input  logic [2*NSRC-1:0] src_lvl,
  input  logic [NNMI-1:0]   nmi_en,
  input  logic              gie,
  input  logic [2:0]        lvl_active,
  input  logic              nmi_active,
  output logic              req,
  output logic [IW-1:0]     win_idx,
  output logic              win_nmi,
  output logic [1:0]        win_lvl
);

  logic          nmi_hit;
  logic [IW-1:0] nmi_idx;
  logic          mk_hit;
  logic [IW-1:0] mk_idx;
  logic [1:0]    mk_lvl;
  logic [1:0]    floor_lvl;
  logic [1:0]    cur_lvl;

  // non-maskable class: scan from the top so the lowest index is kept last
  always_comb begin
    nmi_hit = 1'b0;
    nmi_idx = '0;
    for (int i = NNMI - 1; i >= 0; i--) begin
      if (flags[i] && nmi_en[i] && !nmi_active) begin
        nmi_hit = 1'b1;
        nmi_idx = IW'(i);
      end
    end
  end

  // maskable class: highest level, ties to the lowest index
  always_comb begin
    floor_lvl = top_level(lvl_active);
    mk_hit    = 1'b0;
    mk_idx    = '0;
    mk_lvl    = 2'd0;
    cur_lvl   = 2'd0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      cur_lvl = src_lvl[2*i +: 2];
      if (flags[NNMI+i] && src_en[i] && gie && !nmi_active &&
          (cur_lvl > floor_lvl) && (cur_lvl >= mk_lvl)) begin
        mk_hit = 1'b1;
        mk_idx = IW'(NNMI + i);
        mk_lvl = cur_lvl;
      end
    end
  end

  assign req     = nmi_hit || mk_hit;
  assign win_nmi = nmi_hit;
  assign win_idx = nmi_hit ? nmi_idx : mk_idx;
  assign win_lvl = mk_lvl;

endmodule

// File: rtl/irq_level_track.sv
module irq_level_track
  import irq_hub_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic       take_nmi,
  input  logic [1:0] take_lvl,
  input  logic       reti,
  output logic [2:0] lvl_active,
  output logic       nmi_active
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_active <= 3'b000;
      nmi_active <= 1'b0;
    end else if (take) begin
      if (take_nmi) begin
        nmi_active <= 1'b1;
      end else begin
        lvl_active <= lvl_active | lvl_onehot(take_lvl);
      end
    end else if (reti) begin
      if (nmi_active) begin
        nmi_active <= 1'b0;
      end else begin
        lvl_active <= lvl_active & ~lvl_onehot(top_level(lvl_active));
      end
    end
  end

endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer
  import irq_hub_pkg::*;
#(
  parameter int PUSH_CYC = 5,
  parameter int JUMP_CYC = 3,
  parameter int LOCK_CYC = 4,
  parameter int IW       = 4,
  parameter int AW       = 16,
  parameter logic [AW-1:0] VEC_BASE = 16'h0040
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [IW-1:0] win_idx,
  input  logic          core_boundary,
  input  logic          ccp_unlock,
  input  logic          reti,
  input  logic          vec_ready,
  output logic          take,
  output logic          busy,
  output logic          vec_valid,
  output logic [AW-1:0] vec_addr
);

  localparam int MAXC = (PUSH_CYC > JUMP_CYC) ? PUSH_CYC : JUMP_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int LW   = $clog2(LOCK_CYC + 1);

  seq_state_e    state;
  logic [CW-1:0] phase_cnt;
  logic [LW-1:0] lock_cnt;
  logic          lock_block;

  assign lock_block = ccp_unlock || (lock_cnt != '0);
  assign take = (state == SEQ_IDLE) && req && core_boundary && !lock_block && !reti;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_cnt <= '0;
    end else if (ccp_unlock) begin
      lock_cnt <= LW'(LOCK_CYC - 1);
    end else if (lock_cnt != '0) begin
      lock_cnt <= lock_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SEQ_IDLE;
      phase_cnt <= '0;
      vec_addr  <= '0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          if (take) begin
            state     <= SEQ_PUSH;
            phase_cnt <= '0;
            vec_addr  <= VEC_BASE + ((AW'(win_idx) + AW'(1)) << 1);
          end
        end
        SEQ_PUSH: begin
          if (phase_cnt == CW'(PUSH_CYC - 1)) begin
            state     <= SEQ_JUMP;
            phase_cnt <= '0;
          end else begin
            phase_cnt <= phase_cnt + 1'b1;
          end
        end
        SEQ_JUMP: begin
          if (phase_cnt == CW'(JUMP_CYC - 1)) begin
            state     <= SEQ_VEC;
            phase_cnt <= '0;
          end else begin
            phase_cnt <= phase_cnt + 1'b1;
          end
        end
        SEQ_VEC: begin
          if (vec_ready) begin
            state <= SEQ_IDLE;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assign busy      = (state != SEQ_IDLE);
  assign vec_valid = (state == SEQ_VEC);

endmodule

// File: rtl/irq_hub.sv
module irq_hub #(
  parameter int NSRC     = 8,
  parameter int NNMI     = 2,
  parameter int AW       = 16,
  parameter logic [AW-1:0] VEC_BASE = 16'h0040,
  parameter int PUSH_CYC = 5,
  parameter int JUMP_CYC = 3,
  parameter int LOCK_CYC = 4,
  localparam int NT      = NNMI + NSRC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_event,
  input  logic [NNMI-1:0]   nmi_event,
  input  logic [NT-1:0]     flag_clr,
  input  logic [NSRC-1:0]   src_en,
  input  logic [2*NSRC-1:0] src_lvl,
  input  logic [NNMI-1:0]   nmi_en,
  input  logic              gie_we,
  input  logic              gie_wdata,
  input  logic              ccp_unlock,
  input  logic              core_boundary,
  input  logic              reti,
  input  logic              vec_ready,
  output logic              gie,
  output logic [NT-1:0]     flags,
  output logic [2:0]        lvl_active,
  output logic              nmi_active,
  output logic              busy,
  output logic              vec_valid,
  output logic [AW-1:0]     vec_addr
);

  localparam int IW = $clog2(NT + 1);

  logic          req;
  logic [IW-1:0] win_idx;
  logic          win_nmi;
  logic [1:0]    win_lvl;
  logic          take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie <= 1'b0;
    end else if (gie_we) begin
      gie <= gie_wdata;
    end
  end

  irq_flags #(.NT(NT), .IW(IW)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_pulse({src_event, nmi_event}),
    .clr_w1c  (flag_clr),
    .take     (take),
    .take_idx (win_idx),
    .flags    (flags)
  );

  irq_arbiter #(.NSRC(NSRC), .NNMI(NNMI), .IW(IW)) u_arb (
    .flags      (flags),
    .src_en     (src_en),
    .src_lvl    (src_lvl),
    .nmi_en     (nmi_en),
    .gie        (gie),
    .lvl_active (lvl_active),
    .nmi_active (nmi_active),
    .req        (req),
    .win_idx    (win_idx),
    .win_nmi    (win_nmi),
    .win_lvl    (win_lvl)
  );

  irq_level_track u_lvl (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .take_nmi   (win_nmi),
    .take_lvl   (win_lvl),
    .reti       (reti),
    .lvl_active (lvl_active),
    .nmi_active (nmi_active)
  );

  irq_sequencer #(
    .PUSH_CYC(PUSH_CYC), .JUMP_CYC(JUMP_CYC), .LOCK_CYC(LOCK_CYC),
    .IW(IW), .AW(AW), .VEC_BASE(VEC_BASE)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .req           (req),
    .win_idx       (win_idx),
    .core_boundary (core_boundary),
    .ccp_unlock    (ccp_unlock),
    .reti          (reti),
    .vec_ready     (vec_ready),
    .take          (take),
    .busy          (busy),
    .vec_valid     (vec_valid),
    .vec_addr      (vec_addr)
  );

endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
  parameter int NSRC = 8,
  parameter int NNMI = 2,
  parameter int AW   = 16,
  localparam int NT  = NNMI + NSRC
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_event,
  input logic [NNMI-1:0] nmi_event,
  input logic [NT-1:0]   flag_clr,
  input logic            gie_we,
  input logic            ccp_unlock,
  input logic            core_boundary,
  input logic            reti,
  input logic            vec_ready,
  input logic            gie,
  input logic [NT-1:0]   flags,
  input logic [2:0]      lvl_active,
  input logic            nmi_active,
  input logic            busy,
  input logic            vec_valid,
  input logic [AW-1:0]   vec_addr
);

  logic [NT-1:0] ev;
  assign ev = {src_event, nmi_event};

  for (genvar k = 0; k < NT; k++) begin : g_flag_chk
    p_flag_latch_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ev[k] |=> flags[k]);
    p_w1c_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr[k] && !ev[k]) |=> !flags[k]);
  end

  p_gie_only_written_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_we |=> (gie == $past(gie)));

  p_nmi_not_preempted_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(nmi_active));

  p_vec_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ready) |=> (vec_valid && $stable(vec_addr)));

  p_vec_inside_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> busy);

  p_boundary_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(core_boundary));

  p_unlock_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(ccp_unlock));

  p_level_kept_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !reti |=> ((($past(lvl_active) & ~lvl_active) == 3'b000) &&
               (!$past(nmi_active) || nmi_active)));

  p_level_set_on_take_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(busy) |-> ((lvl_active & ~$past(lvl_active)) == 3'b000));

endmodule

bind irq_hub irq_hub_chk #(.NSRC(NSRC), .NNMI(NNMI), .AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .src_event     (src_event),
  .nmi_event     (nmi_event),
  .flag_clr      (flag_clr),
  .gie_we        (gie_we),
  .ccp_unlock    (ccp_unlock),
  .core_boundary (core_boundary),
  .reti          (reti),
  .vec_ready     (vec_ready),
  .gie           (gie),
  .flags         (flags),
  .lvl_active    (lvl_active),
  .nmi_active    (nmi_active),
  .busy          (busy),
  .vec_valid     (vec_valid),
  .vec_addr      (vec_addr)
);

// File: tb/test_irq_hub.sv
`timescale 1ns/1ps
module test_irq_hub;

  localparam int NSRC = 8;
  localparam int NNMI = 2;
  localparam int AW   = 16;
  localparam int NT   = NNMI + NSRC;
  localparam logic [AW-1:0] BASE = 16'h0040;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NSRC-1:0]   src_event = '0;
  logic [NNMI-1:0]   nmi_event = '0;
  logic [NT-1:0]     flag_clr = '0;
  logic [NSRC-1:0]   src_en = '0;
  logic [2*NSRC-1:0] src_lvl = '0;
  logic [NNMI-1:0]   nmi_en = '0;
  logic              gie_we = 1'b0;
  logic              gie_wdata = 1'b0;
  logic              ccp_unlock = 1'b0;
  logic              core_boundary = 1'b0;
  logic              reti = 1'b0;
  logic              vec_ready = 1'b0;
  logic              gie;
  logic [NT-1:0]     flags;
  logic [2:0]        lvl_active;
  logic              nmi_active;
  logic              busy;
  logic              vec_valid;
  logic [AW-1:0]     vec_addr;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit gie_v  = 1'b0;

  irq_hub #(.NSRC(NSRC), .NNMI(NNMI), .AW(AW), .VEC_BASE(BASE)) i_irq_hub (.*);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] addr_of(input int v);
    return BASE + AW'(2 * v);
  endfunction

  // expected winner (1-based vector index, 0 = none) from the requirements
  function automatic int model(input logic [NT-1:0] f, input logic [NSRC-1:0] en,
                               input logic [2*NSRC-1:0] lv, input logic [NNMI-1:0] nen,
                               input bit g, input int floor, input bit nmi_busy);
    if (nmi_busy) return 0;
    for (int i = 0; i < NNMI; i++)
      if (f[i] && nen[i]) return i + 1;
    if (!g) return 0;
    for (int l = 3; l > floor; l--)
      for (int i = 0; i < NSRC; i++)
        if (f[NNMI+i] && en[i] && int'(lv[2*i +: 2]) == l) return NNMI + i + 1;
    return 0;
  endfunction

  task automatic set_gie(input bit v);
    gie_we = 1'b1; gie_wdata = v;
    @(negedge clk);
    gie_we = 1'b0; gie_v = v;
  endtask

  task automatic pulse_src(input int i);
    src_event[i] = 1'b1;
    @(negedge clk);
    src_event = '0;
  endtask

  task automatic pulse_nmi(input int i);
    nmi_event[i] = 1'b1;
    @(negedge clk);
    nmi_event = '0;
  endtask

  task automatic do_reti;
    reti = 1'b1;
    @(negedge clk);
    reti = 1'b0;
  endtask

  task automatic expect_idle(input int n, input string tag);
    core_boundary = 1'b1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check(!busy, tag, busy, 0);
    end
    core_boundary = 1'b0;
  endtask

  task automatic serve(input logic [AW-1:0] exp, input string tag, input int hold);
    int n;
    n = 0;
    core_boundary = 1'b1;
    while (!busy && n < 40) begin @(negedge clk); n++; end
    check(busy, {tag, " take"}, busy, 1);
    core_boundary = 1'b0;
    n = 0;
    while (!vec_valid && n < 40) begin @(negedge clk); n++; end
    check(n == 8, "R9 entry latency", n, 8);
    check(vec_addr == exp, {tag, " R14 vector"}, vec_addr, exp);
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check(vec_valid && vec_addr == exp, "R9 hold under back-pressure", vec_addr, exp);
    end
    vec_ready = 1'b1;
    @(negedge clk);
    vec_ready = 1'b0;
    check(!busy && !vec_valid, "R9 beat done", busy, 0);
  endtask

  initial begin
    logic [NT-1:0] snap;
    int w;
    void'($urandom(32'd20240));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    check(flags == '0, "R1 reset flags", flags, 0);
    check(gie == 1'b0, "R6 reset gie", gie, 0);
    check(!busy && !vec_valid, "R9 reset idle", busy, 0);
    check(lvl_active == 3'b000 && !nmi_active, "R12 reset levels", lvl_active, 0);

    // R1: latch while disabled; set wins over clear
    pulse_src(3);
    check(flags[NNMI+3], "R1 latch disabled", flags, 1 << (NNMI + 3));
    flag_clr[NNMI+3] = 1'b1; src_event[3] = 1'b1;
    @(negedge clk);
    flag_clr = '0; src_event = '0;
    check(flags[NNMI+3], "R1 set beats clear", flags[NNMI+3], 1);
    // R3: write-one clear
    flag_clr[NNMI+3] = 1'b1;
    @(negedge clk);
    flag_clr = '0;
    check(flags == '0, "R3 w1c", flags, 0);

    // R13/R4: gie off holds maskable; R6: NMI still taken, gie untouched
    src_en = 8'h07; src_lvl = 16'b11_01_01;
    pulse_src(0);
    expect_idle(10, "R13 gie off holds maskable");
    check(flags[NNMI+0], "R4 held while gie off", flags[NNMI+0], 1);
    pulse_nmi(0);
    expect_idle(5, "R5 nmi not enabled");
    nmi_en = 2'b11;
    serve(addr_of(1), "R6 nmi with gie off", 0);
    check(gie == 1'b0, "R6 gie unchanged by nmi", gie, 0);
    check(nmi_active && !flags[0], "R2 nmi flag cleared", flags[0], 0);
    // R7: second NMI blocked while first in service
    pulse_nmi(1);
    expect_idle(10, "R7 nmi not preempted");
    do_reti;
    check(!nmi_active, "R12 reti clears nmi", nmi_active, 0);
    serve(addr_of(2), "R8 second nmi", 0);
    do_reti;
    set_gie(1'b1);
    check(gie == 1'b1, "R6 gie write", gie, 1);
    serve(addr_of(3), "R4 held maskable served", 0);
    check(lvl_active == 3'b001, "R13 low level active", lvl_active, 1);

    // R12: no change without reti
    repeat (20) @(negedge clk);
    check(lvl_active == 3'b001, "R12 level kept without reti", lvl_active, 1);
    // R13: same level blocked, higher level preempts
    pulse_src(1);
    expect_idle(10, "R13 equal level blocked");
    pulse_src(2);
    serve(addr_of(5), "R13 high preempts low", 2);
    check(lvl_active == 3'b101, "R13 nested levels", lvl_active, 5);
    do_reti;
    check(lvl_active == 3'b001, "R12 reti clears top", lvl_active, 1);
    expect_idle(5, "R13 still blocked by low");
    do_reti;
    serve(addr_of(4), "R4 pending low after reti", 0);
    do_reti;

    // R10: core not at boundary
    pulse_src(0);
    core_boundary = 1'b0;
    repeat (10) begin @(negedge clk); check(!busy, "R10 wait for boundary", busy, 0); end
    // R11: unlock window
    ccp_unlock = 1'b1; core_boundary = 1'b1;
    @(negedge clk);
    ccp_unlock = 1'b0;
    check(!busy, "R11 blocked at unlock", busy, 0);
    repeat (3) begin @(negedge clk); check(!busy, "R11 blocked window", busy, 0); end
    @(negedge clk);
    check(busy, "R11 released after window", busy, 1);
    serve(addr_of(3), "R11 serve", 0);
    do_reti;

    // R8: equal level lowest index, NMI beats high maskable
    src_lvl = 16'b11_11_11; src_en = 8'h07;
    src_event = 8'h06; nmi_event = 2'b10;
    @(negedge clk);
    src_event = '0; nmi_event = '0;
    serve(addr_of(2), "R8 nmi first", 0);
    do_reti;
    serve(addr_of(4), "R8 lowest index at equal level", 0);
    do_reti;
    serve(addr_of(5), "R8 next index", 0);
    do_reti;

    // constrained random rounds
    for (int it = 0; it < 40; it++) begin
      src_en  = NSRC'($urandom);
      src_lvl = (2*NSRC)'($urandom);
      nmi_en  = NNMI'($urandom);
      set_gie((it % 5) != 0);
      src_event = NSRC'($urandom);
      nmi_event = ($urandom % 3 == 0) ? NNMI'($urandom) : '0;
      @(negedge clk);
      src_event = '0; nmi_event = '0;
      for (int k = 0; k < NT + 2; k++) begin
        snap = flags;
        w = model(snap, src_en, src_lvl, nmi_en, gie_v, 0, 1'b0);
        if (w == 0) begin
          expect_idle(6, "R4 nothing eligible");
          break;
        end
        serve(addr_of(w), "R8 random winner", it % 3);
        check(!flags[w-1], "R2 taken flag cleared", flags[w-1], 0);
        do_reti;
        check(lvl_active == 3'b000 && !nmi_active, "R12 reti empties", lvl_active, 0);
      end
      flag_clr = '1;
      @(negedge clk);
      flag_clr = '0;
      check(flags == '0, "R3 clear all", flags, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule